// File: doc/BRIEF.md
# Video Input Window Conditioner

This block conditions a raw parallel video stream coming from a sensor-style port. The stream is a 16-bit pixel bus with a horizontal sync and a vertical sync. Each sync can arrive active-low or active-high, and the block converts both to active-high before it uses them. The pixel data can be inverted bit for bit. The block then cuts a rectangular active window out of every frame. The window is given as a starting clock cycle and a cycle count within each line, and as a starting line and a line count within each frame.

The pixel word is shaped according to its format. For raw sensor data, a 4-bit code picks a 12-bit field out of the 16-bit word; some codes shift the field up and fill the low bits with zeros. For 16-bit luma/chroma data, the two bytes can be exchanged. The output is registered and carries a valid flag, a line-start marker and a frame-start marker.

Configuration is written through a small address/data register port. The window fields and the format fields are held in a staging copy. They take effect only at the next vertical sync edge, so a write made in the middle of a frame never changes that frame. The two sync polarity bits take effect at once, because the block needs them to find that edge.

Top module: `vid_window_cond`

## Requirements
- R1: Register address 0 holds the sync polarity: bit 0 set means the horizontal sync input is active-low, and bit 1 set means the vertical sync input is active-low. A written value applies from the next sampled input onward. Line and frame events fire on the rising edge of the normalized (active-high) sync.
- R2: Format bit 0 (register address 1) set replaces the sampled pixel word with its one's complement before any field selection. When the bit is clear, the word passes through unchanged.
- R3: The clock cycle on which the normalized horizontal sync rises is cycle 0 of a line. Pixels are valid from cycle H-start (address 2) through cycle H-start + H-length (address 3), which is H-length+1 cycles.
- R4: The line opened by the first horizontal rise at or after the vertical rise is line 0; every later horizontal rise advances the line. Lines V-start (address 4) through V-start + V-length (address 5) are active, which is V-length+1 lines. Nothing is valid before the first vertical rise.
- R5: Addresses 1 to 5 are staged. A staged value becomes effective on the cycle of the next vertical rising edge, including for that edge's own pixel. A write made mid-frame leaves the current frame unchanged.
- R6: Format bits 2:1 select the mode: 0 is raw, 1 is 16-bit luma/chroma, and 2 or 3 is 8-bit luma/chroma. In raw mode, selector bits 7:4 with code k from 0 to 8 give output bit i = word bit (i+4-k) for i from 0 to 11, and 0 where that index is below zero. Output bits 15:12 are zero.
- R7: In raw mode, selector codes 9 to 15 give zero pixel data. When such a code becomes effective at a vertical edge, a sticky error flag rises and stays high until reset.
- R8: In both luma/chroma modes the selector is ignored and raises no error. In 8-bit mode the 16-bit word passes unchanged, and the swap bit has no effect.
- R9: In 16-bit luma/chroma mode, format bit 3 set exchanges bits 15:8 with bits 7:0.
- R10: The line-start output is high with the first valid pixel of each active line. The frame-start output is high only with the first valid pixel of line V-start.
- R11: Outputs are registered. Inputs present at the pins before clock edge k appear at the outputs after edge k+1.
- R12: After reset, every output is zero, all configuration fields are zero, and no line is active until a vertical edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 polarity, 1 format, 2 H-start, 3 H-length, 4 V-start, 5 V-length) |
| cfg_wdata | input | 15 | Register write data |
| hd_in | input | 1 | Horizontal sync from the sensor port |
| vd_in | input | 1 | Vertical sync from the sensor port |
| pix_in | input | 16 | Pixel data from the sensor port |
| pix_out | output | 16 | Conditioned pixel data |
| pix_vld | output | 1 | Pixel inside the active window |
| line_start | output | 1 | First valid pixel of a line |
| frame_start | output | 1 | First valid pixel of a frame |
| cfg_err | output | 1 | Sticky reserved-selector flag |

## Verification
The window is exercised with several start and length settings, on frames whose vertical sync line is line 0. This separates an off-by-one on the start cycle or start line from an off-by-one on the inclusive end. Some frames carry configuration writes in their third line. These show whether a staged value leaks into the running frame, and whether it lands on the vertical edge itself. The raw selector is run with codes that shift down, codes that shift up, and reserved codes, on pixel words that differ in every nibble, so a wrong bit index is visible. A selector code is set that would be reserved in raw mode, and the block is run in the luma/chroma modes with swap on and off. This distinguishes ignoring the selector from applying it, and applying the swap in the correct mode only. Inverted-polarity frames show whether events still fire on the normalized rising edge.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
  typedef enum logic [1:0] {
    MODE_RAW  = 2'd0,
    MODE_YC16 = 2'd1,
    MODE_YC8  = 2'd2,
    MODE_YC8B = 2'd3
  } vmode_e;

  typedef struct packed {
    logic       inv;
    vmode_e     mode;
    logic       swap;
    logic [3:0] sel;
  } fmt_t;

  localparam logic [2:0] ADDR_POL  = 3'd0;
  localparam logic [2:0] ADDR_FMT  = 3'd1;
  localparam logic [2:0] ADDR_HSTA = 3'd2;
  localparam logic [2:0] ADDR_HLEN = 3'd3;
  localparam logic [2:0] ADDR_VSTA = 3'd4;
  localparam logic [2:0] ADDR_VLEN = 3'd5;
endpackage

// File: rtl/vwc_sync_norm.sv
module vwc_sync_norm #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd_in,
  input  logic          vd_in,
  input  logic [DW-1:0] pix_in,
  input  logic          hd_neg,
  input  logic          vd_neg,
  output logic [DW-1:0] pix_s,
  output logic          hd_rise,
  output logic          vd_rise
);
  logic hd_s, vd_s, hd_q, vd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_s <= '0;
      hd_s  <= 1'b0;
      vd_s  <= 1'b0;
      hd_q  <= 1'b0;
      vd_q  <= 1'b0;
    end else begin
      pix_s <= pix_in;
      hd_s  <= hd_in ^ hd_neg;
      vd_s  <= vd_in ^ vd_neg;
      hd_q  <= hd_s;
      vd_q  <= vd_s;
    end
  end

  assign hd_rise = hd_s & ~hd_q;
  assign vd_rise = vd_s & ~vd_q;

  // R1: a normalized edge is a single-cycle event
  a_r1_hd_single: assert property (@(posedge clk) disable iff (!rst_n)
    hd_rise |=> !hd_rise);
  a_r1_vd_single: assert property (@(posedge clk) disable iff (!rst_n)
    vd_rise |=> !vd_rise);
endmodule

// File: rtl/vwc_cfg.sv
module vwc_cfg
  import vwc_pkg::*;
#(
  parameter int CW      = 15,
  parameter int SEL_MAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          vd_rise,
  output logic          hd_neg,
  output logic          vd_neg,
  output fmt_t          eff_fmt,
  output logic [CW-1:0] eff_hsta,
  output logic [CW-1:0] eff_hlen,
  output logic [CW-1:0] eff_vsta,
  output logic [CW-1:0] eff_vlen,
  output logic          cfg_err
);
  fmt_t          stg_fmt, shd_fmt;
  logic [CW-1:0] stg_hsta, stg_hlen, stg_vsta, stg_vlen;
  logic [CW-1:0] shd_hsta, shd_hlen, shd_vsta, shd_vlen;
  logic          stg_bad;

  function automatic fmt_t decode_fmt(input logic [CW-1:0] w);
    fmt_t f;
    f.inv  = w[0];
    f.mode = vmode_e'(w[2:1]);
    f.swap = w[3];
    f.sel  = w[7:4];
    return f;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_neg   <= 1'b0;
      vd_neg   <= 1'b0;
      stg_fmt  <= '0;
      stg_hsta <= '0;
      stg_hlen <= '0;
      stg_vsta <= '0;
      stg_vlen <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        ADDR_POL:  begin hd_neg <= cfg_wdata[0]; vd_neg <= cfg_wdata[1]; end
        ADDR_FMT:  stg_fmt  <= decode_fmt(cfg_wdata);
        ADDR_HSTA: stg_hsta <= cfg_wdata;
        ADDR_HLEN: stg_hlen <= cfg_wdata;
        ADDR_VSTA: stg_vsta <= cfg_wdata;
        ADDR_VLEN: stg_vlen <= cfg_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_fmt  <= '0;
      shd_hsta <= '0;
      shd_hlen <= '0;
      shd_vsta <= '0;
      shd_vlen <= '0;
    end else if (vd_rise) begin
      shd_fmt  <= stg_fmt;
      shd_hsta <= stg_hsta;
      shd_hlen <= stg_hlen;
      shd_vsta <= stg_vsta;
      shd_vlen <= stg_vlen;
    end
  end

  // the edge cycle itself already uses the staged values
  assign eff_fmt  = vd_rise ? stg_fmt  : shd_fmt;
  assign eff_hsta = vd_rise ? stg_hsta : shd_hsta;
  assign eff_hlen = vd_rise ? stg_hlen : shd_hlen;
  assign eff_vsta = vd_rise ? stg_vsta : shd_vsta;
  assign eff_vlen = vd_rise ? stg_vlen : shd_vlen;

  assign stg_bad = (stg_fmt.mode == MODE_RAW) && (int'(stg_fmt.sel) > SEL_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cfg_err <= 1'b0;
    else if (vd_rise && stg_bad) cfg_err <= 1'b1;
  end

  // R5: shadow copy moves only on a vertical edge
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_rise |=> $stable(shd_hsta) && $stable(shd_hlen) && $stable(shd_vsta)
                 && $stable(shd_vlen) && $stable(shd_fmt));
  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/vwc_window.sv
module vwc_window #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd_rise,
  input  logic          vd_rise,
  input  logic [CW-1:0] hsta,
  input  logic [CW-1:0] hlen,
  input  logic [CW-1:0] vsta,
  input  logic [CW-1:0] vlen,
  output logic          h_hit,
  output logic          v_hit,
  output logic          h_first,
  output logic          v_first
);
  localparam int NW = CW + 1;
  localparam logic [NW-1:0] CNT_TOP  = '1;
  localparam logic [NW-1:0] LINE_SAT = CNT_TOP - NW'(1);

  logic [NW-1:0] pcnt_q, pcur, lcnt_q, lcur;

  function automatic logic in_span(input logic [NW-1:0] c,
                                   input logic [CW-1:0] start,
                                   input logic [CW-1:0] len);
    logic [NW-1:0] last;
    last = NW'(start) + NW'(len);
    return (c >= NW'(start)) && (c <= last);
  endfunction

  always_comb begin
    if (hd_rise)              pcur = '0;
    else if (pcnt_q == CNT_TOP) pcur = pcnt_q;
    else                      pcur = pcnt_q + NW'(1);
  end

  // all-ones line count means "no line opened since the frame edge"
  always_comb begin
    if (vd_rise)               lcur = hd_rise ? '0 : CNT_TOP;
    else if (!hd_rise)         lcur = lcnt_q;
    else if (lcnt_q == LINE_SAT) lcur = lcnt_q;
    else                       lcur = lcnt_q + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= CNT_TOP;
      lcnt_q <= CNT_TOP;
    end else begin
      pcnt_q <= pcur;
      lcnt_q <= lcur;
    end
  end

  assign h_hit   = in_span(pcur, hsta, hlen);
  assign v_hit   = (lcur != CNT_TOP) && in_span(lcur, vsta, vlen);
  assign h_first = (pcur == NW'(hsta));
  assign v_first = (lcur == NW'(vsta));

  // R3: the first-pixel cycle cannot repeat on the next cycle
  a_r3_first_once: assert property (@(posedge clk) disable iff (!rst_n)
    h_first |=> !h_first);
  // R4: the line count only moves on a sync edge
  a_r4_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_rise && !vd_rise |-> lcur == lcnt_q);
endmodule

// File: rtl/vwc_datapath.sv
module vwc_datapath
  import vwc_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 12
) (
  input  logic [DW-1:0] pix_s,
  input  fmt_t          fmt,
  output logic [DW-1:0] pix_fmt
);
  localparam int SHIFT   = DW - OW;
  localparam int SEL_MAX = 2 * SHIFT;
  localparam int HALF    = DW / 2;

  // code k: output bit i takes input bit i + SHIFT - k, zero below bit 0
  function automatic logic [OW-1:0] raw_pick(input logic [DW-1:0] d,
                                             input logic [3:0]    sel);
    logic [OW-1:0] r;
    r = '0;
    if (int'(sel) <= SEL_MAX) begin
      for (int i = 0; i < OW; i++) begin
        int src;
        src = i + SHIFT - int'(sel);
        if (src >= 0) r[i] = d[src];
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] byte_swap(input logic [DW-1:0] d);
    return {d[HALF-1:0], d[DW-1:HALF]};
  endfunction

  logic [DW-1:0] pol_d;

  assign pol_d = fmt.inv ? ~pix_s : pix_s;

  always_comb begin
    case (fmt.mode)
      MODE_RAW:  pix_fmt = {{SHIFT{1'b0}}, raw_pick(pol_d, fmt.sel)};
      MODE_YC16: pix_fmt = fmt.swap ? byte_swap(pol_d) : pol_d;
      default:   pix_fmt = pol_d;
    endcase
  end
endmodule

// File: rtl/vid_window_cond.sv
module vid_window_cond
  import vwc_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 12,
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          hd_in,
  input  logic          vd_in,
  input  logic [DW-1:0] pix_in,
  output logic [DW-1:0] pix_out,
  output logic          pix_vld,
  output logic          line_start,
  output logic          frame_start,
  output logic          cfg_err
);
  localparam int SEL_MAX = 2 * (DW - OW);

  logic          hd_neg, vd_neg, hd_rise, vd_rise;
  logic [DW-1:0] pix_s, pix_fmt;
  fmt_t          eff_fmt;
  logic [CW-1:0] eff_hsta, eff_hlen, eff_vsta, eff_vlen;
  logic          h_hit, v_hit, h_first, v_first;
  logic          win_hit, raw_q;

  vwc_sync_norm #(.DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .hd_in(hd_in), .vd_in(vd_in), .pix_in(pix_in),
    .hd_neg(hd_neg), .vd_neg(vd_neg), .pix_s(pix_s),
    .hd_rise(hd_rise), .vd_rise(vd_rise));

  vwc_cfg #(.CW(CW), .SEL_MAX(SEL_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .vd_rise(vd_rise), .hd_neg(hd_neg), .vd_neg(vd_neg),
    .eff_fmt(eff_fmt), .eff_hsta(eff_hsta), .eff_hlen(eff_hlen),
    .eff_vsta(eff_vsta), .eff_vlen(eff_vlen), .cfg_err(cfg_err));

  vwc_window #(.CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .hd_rise(hd_rise), .vd_rise(vd_rise),
    .hsta(eff_hsta), .hlen(eff_hlen), .vsta(eff_vsta), .vlen(eff_vlen),
    .h_hit(h_hit), .v_hit(v_hit), .h_first(h_first), .v_first(v_first));

  vwc_datapath #(.DW(DW), .OW(OW)) u_dp (
    .pix_s(pix_s), .fmt(eff_fmt), .pix_fmt(pix_fmt));

  assign win_hit = h_hit & v_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out     <= '0;
      pix_vld     <= 1'b0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
      raw_q       <= 1'b0;
    end else begin
      pix_out     <= pix_fmt;
      pix_vld     <= win_hit;
      line_start  <= win_hit & h_first;
      frame_start <= win_hit & h_first & v_first;
      raw_q       <= (eff_fmt.mode == MODE_RAW);
    end
  end

  // R10: markers only accompany valid pixels
  a_r10_line_mark: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pix_vld);
  a_r10_frame_mark: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);
  // R6: raw output leaves the upper bits clear
  a_r6_raw_upper: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q |-> pix_out[DW-1:OW] == '0);
endmodule

// File: tb/vid_window_cond_test.sv
module vid_window_cond_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [14:0] cfg_wdata = '0;
  logic        hd_in = 1'b0, vd_in = 1'b0;
  logic [15:0] pix_in = '0;
  logic [15:0] pix_out;
  logic        pix_vld, line_start, frame_start, cfg_err;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  vid_window_cond uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hd_in(hd_in), .vd_in(vd_in), .pix_in(pix_in),
    .pix_out(pix_out), .pix_vld(pix_vld), .line_start(line_start),
    .frame_start(frame_start), .cfg_err(cfg_err));

  typedef struct {
    logic        vld;
    logic [15:0] data;
    logic        ls;
    logic        fs;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // reference state
  logic m_hneg = 0, m_vneg = 0, m_hp = 0, m_vp = 0, m_err = 0;
  int   m_p = 65535, m_l = -1;
  int   s_hsta, s_hlen, s_vsta, s_vlen, s_inv, s_mode, s_swap, s_sel;
  int   e_hsta, e_hlen, e_vsta, e_vlen, e_inv, e_mode, e_swap, e_sel;
  string cur_tag = "R12 reset";

  // mid-frame writes for the frame task
  int          n_mid = 0;
  logic [2:0]  mid_a [3];
  logic [14:0] mid_d [3];
  int          seed = 0;

  function automatic logic [14:0] fmtw(int inv, int mode, int swap, int sel);
    return 15'((sel << 4) | (swap << 3) | (mode << 1) | inv);
  endfunction

  function automatic logic [15:0] pick_ref(logic [15:0] d, int code);
    case (code)
      0: return {4'h0, d[15:4]};
      1: return {4'h0, d[14:3]};
      2: return {4'h0, d[13:2]};
      3: return {4'h0, d[12:1]};
      4: return {4'h0, d[11:0]};
      5: return {4'h0, d[10:0], 1'b0};
      6: return {4'h0, d[9:0], 2'b0};
      7: return {4'h0, d[8:0], 3'b0};
      8: return {4'h0, d[7:0], 4'b0};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic step(input logic hl, input logic vl, input logic [15:0] pix,
                      input logic wr, input logic [2:0] a, input logic [14:0] wd);
    exp_t e;
    logic hdr, vdr;
    logic [15:0] d;
    @(negedge clk);
    hd_in = hl ^ m_hneg;
    vd_in = vl ^ m_vneg;
    pix_in = pix;
    cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
    if (wr) begin
      case (a)
        3'd1: begin s_inv = wd[0]; s_mode = wd[2:1]; s_swap = wd[3]; s_sel = wd[7:4]; end
        3'd2: s_hsta = wd;
        3'd3: s_hlen = wd;
        3'd4: s_vsta = wd;
        3'd5: s_vlen = wd;
        default: ;
      endcase
    end
    hdr = hl && !m_hp;
    vdr = vl && !m_vp;
    m_hp = hl; m_vp = vl;
    if (vdr) begin
      e_hsta = s_hsta; e_hlen = s_hlen; e_vsta = s_vsta; e_vlen = s_vlen;
      e_inv = s_inv; e_mode = s_mode; e_swap = s_swap; e_sel = s_sel;
      if (s_mode == 0 && s_sel > 8) m_err = 1;
    end
    if (hdr) m_p = 0; else if (m_p < 65535) m_p++;
    if (vdr) m_l = hdr ? 0 : -1;
    else if (hdr && m_l < 65534) m_l++;
    e.vld = (m_p >= e_hsta) && (m_p <= e_hsta + e_hlen) &&
            (m_l >= 0) && (m_l >= e_vsta) && (m_l <= e_vsta + e_vlen);
    e.ls = e.vld && (m_p == e_hsta);
    e.fs = e.ls && (m_l == e_vsta);
    d = e_inv ? ~pix : pix;
    if (e_mode == 0)                    e.data = pick_ref(d, e_sel);
    else if (e_mode == 1 && e_swap == 1) e.data = {d[7:0], d[15:8]};
    else                                 e.data = d;
    e.err = m_err;
    e.tag = cur_tag;
    exp_q.push_back(e);
    if (wr && a == 3'd0) begin m_hneg = wd[0]; m_vneg = wd[1]; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 16'h0, 0, 3'd0, 15'h0);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [14:0] wd);
    step(0, 0, 16'h0, 1, a, wd);
  endtask

  // frame: line 0 carries the vertical sync, horizontal sync high for 2 cycles
  task automatic frame(input int nl, input int ll);
    for (int l = 0; l < nl; l++) begin
      for (int c = 0; c < ll; c++) begin
        logic [15:0] px;
        int k;
        px = 16'((l * 16'h1357) + (c * 16'h0F1B) + seed) ^ 16'hA5C3;
        k = c - 4;
        if (l == 2 && k >= 0 && k < n_mid)
          step(c < 2, l == 0, px, 1, mid_a[k], mid_d[k]);
        else
          step(c < 2, l == 0, px, 0, 3'd0, 15'h0);
      end
    end
    n_mid = 0;
    seed += 16'h3C1;
  endtask

  // monitor: compares each registered output with its scoreboard entry
  always @(posedge clk) begin
    #1;
    if (exp_q.size() >= 2) begin
      exp_t e;
      e = exp_q.pop_front();
      tests++;
      if (pix_vld !== e.vld || line_start !== e.ls || frame_start !== e.fs ||
          cfg_err !== e.err || (e.vld && pix_out !== e.data)) begin
        fails++;
        $display("FAIL %s: vld/ls/fs/err/data got %b/%b/%b/%b/%h expected %b/%b/%b/%b/%h",
                 e.tag, pix_vld, line_start, frame_start, cfg_err, pix_out,
                 e.vld, e.ls, e.fs, e.err, e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    s_hsta = 0; s_hlen = 0; s_vsta = 0; s_vlen = 0;
    s_inv = 0; s_mode = 0; s_swap = 0; s_sel = 0;
    e_hsta = 0; e_hlen = 0; e_vsta = 0; e_vlen = 0;
    e_inv = 0; e_mode = 0; e_swap = 0; e_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state at the ports
    tests++;
    if (pix_vld !== 0 || line_start !== 0 || frame_start !== 0 || cfg_err !== 0 || pix_out !== 0) begin
      fails++;
      $display("FAIL R12: outputs after reset got %b/%b/%b/%b/%h expected 0/0/0/0/0000",
               pix_vld, line_start, frame_start, cfg_err, pix_out);
    end
    idle(3);

    cur_tag = "R3 R4 R6 R10 R11 window, raw code 0";
    wr_reg(3'd2, 15'd3); wr_reg(3'd3, 15'd4);
    wr_reg(3'd4, 15'd1); wr_reg(3'd5, 15'd2);
    wr_reg(3'd1, fmtw(0, 0, 0, 0));
    frame(5, 12); frame(5, 12);

    cur_tag = "R5 R2 mid-frame staging, invert, code 5";
    mid_a[0] = 3'd2; mid_d[0] = 15'd0;
    mid_a[1] = 3'd3; mid_d[1] = 15'd6;
    mid_a[2] = 3'd1; mid_d[2] = fmtw(1, 0, 0, 5);
    n_mid = 3;
    frame(5, 12);
    mid_a[0] = 3'd4; mid_d[0] = 15'd0;
    mid_a[1] = 3'd5; mid_d[1] = 15'd4;
    n_mid = 2;
    frame(6, 12);
    frame(6, 12);

    cur_tag = "R1 inverted sync polarity";
    wr_reg(3'd0, 15'd3);
    idle(3);
    wr_reg(3'd4, 15'd2); wr_reg(3'd5, 15'd1);
    wr_reg(3'd2, 15'd2); wr_reg(3'd3, 15'd3);
    frame(5, 10); frame(5, 10);
    wr_reg(3'd0, 15'd0);
    idle(3);

    cur_tag = "R6 raw codes 2 8 4 1 7";
    wr_reg(3'd1, fmtw(0, 0, 0, 2)); frame(5, 10);
    wr_reg(3'd1, fmtw(0, 0, 0, 8)); frame(5, 10);
    wr_reg(3'd1, fmtw(0, 0, 0, 4)); frame(5, 10);
    wr_reg(3'd1, fmtw(1, 0, 0, 1)); frame(5, 10);
    wr_reg(3'd1, fmtw(0, 0, 0, 7)); frame(5, 10);

    cur_tag = "R9 R8 16-bit luma/chroma swap, selector ignored";
    wr_reg(3'd1, fmtw(0, 1, 1, 12)); frame(5, 10);
    wr_reg(3'd1, fmtw(0, 1, 0, 3)); frame(5, 10);
    cur_tag = "R8 8-bit luma/chroma ignores swap and selector";
    wr_reg(3'd1, fmtw(0, 2, 1, 15)); frame(5, 10);
    wr_reg(3'd1, fmtw(1, 3, 1, 9)); frame(5, 10);

    cur_tag = "R7 reserved code zero data, sticky error";
    wr_reg(3'd1, fmtw(0, 0, 0, 12)); frame(5, 10);
    wr_reg(3'd1, fmtw(0, 0, 0, 0)); frame(5, 10);
    idle(4);
    // R7: the flag stays set after a legal code took over
    tests++;
    if (cfg_err !== 1'b1) begin
      fails++;
      $display("FAIL R7: cfg_err got %b expected 1", cfg_err);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule